// File: doc/BRIEF.md
# Programmable Parallel Port Interface

This block is a bus-attached general-purpose parallel I/O peripheral. It has three 8-bit ports, called A, B and C, and one control register. A host reaches all four through a small synchronous bus: an 8-bit write data path, an 8-bit read data path with its own output-enable, an active-low select, active-low read and write strobes, and a 2-bit register address. Each port has an output latch. Each port also has a direction, chosen by the host: it either drives its pins from the latch or lets the host sample the pins live.

Port C is handled as two 4-bit halves, and each half has its own direction. Any single Port C bit can be forced high or low by one write to the control address. No read-modify-write is needed, so control lines such as enables and chip selects can be toggled with one bus cycle. Only the basic (unhandshaked) mode is built. The mode-select bits that would ask for strobed or handshaked operation are ignored, and the port then runs in basic mode.

Top module: `ppi_parallel_io`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, every port becomes an input (`pa_oe`=0, `pb_oe`=0, `pc_oe`=0x00) and all three output latches become 0x00.
- R2: The address selects the target: `addr`=2'b00 is Port A, 2'b01 is Port B, 2'b10 is Port C, 2'b11 is the control register.
- R3: A write takes effect at a rising clock edge where `cs_n` and `wr_n` are both low. Writing a port address loads `wdata` into that port's latch, which then appears on `pa_out`/`pb_out`/`pc_out`. With `cs_n` high, a write strobe changes nothing.
- R4: `rdata_oe` is high exactly while `cs_n` and `rd_n` are both low. Otherwise the read bus is released.
- R5: A read of a port returns the live pins (`pa_in`/`pb_in`/`pc_in`) for bits set as input, and the output latch for bits set as output. For Port C this choice is made per 4-bit half.
- R6: A read of the control address returns 0xFF.
- R7: A control write with bit 7 = 1 is a mode word. Bit 4 sets Port A, bit 3 sets Port C bits 7..4, bit 1 sets Port B, and bit 0 sets Port C bits 3..0. In each of these bits, 1 means input and 0 means output. Bits 6, 5 and 2 are ignored.
- R8: A mode word clears all three output latches to 0x00.
- R9: A control write with bit 7 = 0 is a bit command. Bits 3..1 give the Port C bit index, and bit 0 gives its new value. No other latch bit changes, and all directions stay as they were.
- R10: `pa_oe` and `pb_oe` are high when their port is an output. `pc_oe` carries one enable per Port C pin, and the two halves follow their own direction bits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| cs_n | input | 1 | Active-low peripheral select |
| rd_n | input | 1 | Active-low read strobe |
| wr_n | input | 1 | Active-low write strobe |
| addr | input | 2 | Register address |
| wdata | input | 8 | Host write data |
| rdata | output | 8 | Host read data |
| rdata_oe | output | 1 | Output-enable for the host read data |
| pa_in | input | 8 | Port A pin levels |
| pa_out | output | 8 | Port A output latch |
| pa_oe | output | 1 | Port A drive enable |
| pb_in | input | 8 | Port B pin levels |
| pb_out | output | 8 | Port B output latch |
| pb_oe | output | 1 | Port B drive enable |
| pc_in | input | 8 | Port C pin levels |
| pc_out | output | 8 | Port C output latch |
| pc_oe | output | 8 | Port C per-pin drive enable |

## Verification
The main function is exercised in four direction layouts: all inputs after reset, all outputs, a split layout with Port A and the low half of C driving while B and the high half of C sense, and a mode word that sets only the ignored bits. The split layout uses different values on the Port C pins and the Port C latch, so a read that mixes the two halves shows whether the per-half selection is right. Bit commands set and clear the top bit, the bottom bit and a middle bit in turn. A command that moves the wrong bit, or a direction that shifts, then shows up as a wrong latch value or a wrong enable. A write with select high and a read with select high check that the select gates both directions of the bus.

// File: rtl/ppi_pkg.sv
// Package: shared types and field positions of the parallel port interface.
// Assumes an 8-bit port width for the control word layout.
package ppi_pkg;

    localparam int PORT_W = 8;

    // Register select codes presented on the address pins.
    typedef enum logic [1:0] {
        SEL_A    = 2'b00,
        SEL_B    = 2'b01,
        SEL_C    = 2'b10,
        SEL_CTRL = 2'b11
    } reg_sel_e;

    // Direction state; a set bit means that group is an input.
    typedef struct packed {
        logic a_in;
        logic chi_in;
        logic b_in;
        logic clo_in;
    } dir_t;

    // Field positions inside a control word.
    localparam int CW_KIND_BIT = 7;
    localparam int CW_A_BIT    = 4;
    localparam int CW_CHI_BIT  = 3;
    localparam int CW_B_BIT    = 1;
    localparam int CW_CLO_BIT  = 0;
    localparam int CW_VAL_BIT  = 0;

    localparam dir_t DIR_ALL_IN = '{a_in: 1'b1, chi_in: 1'b1, b_in: 1'b1, clo_in: 1'b1};

endpackage

// File: rtl/ppi_ctrl_reg.sv
// Module: control word decoder and direction register.
// A control write with the kind bit set loads the direction bits and
// requests a clear of all latches. With the kind bit clear, the write
// becomes a one-bit command for Port C. Assumes wr_ctrl is already
// qualified by select and write strobe.
module ppi_ctrl_reg
    import ppi_pkg::*;
#(
    parameter int W     = PORT_W,
    localparam int IDX_W = $clog2(W)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_ctrl,
    input  logic [W-1:0]     wdata,
    output dir_t             dir,
    output logic             mode_load,
    output logic             bit_we,
    output logic [IDX_W-1:0] bit_idx,
    output logic             bit_val
);

    dir_t dir_q;
    logic unused_cw_bits;

    // Split a control write into its two kinds.
    always_comb begin
        mode_load = wr_ctrl &  wdata[CW_KIND_BIT];
        bit_we    = wr_ctrl & ~wdata[CW_KIND_BIT];
        bit_idx   = wdata[IDX_W:1];
        bit_val   = wdata[CW_VAL_BIT];
    end

    // Bits with no meaning in basic mode are consumed here and dropped.
    assign unused_cw_bits = ^{wdata[6:5], wdata[2]};

    // Hold the direction bits; reset makes everything an input.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dir_q <= DIR_ALL_IN;
        end else if (mode_load) begin
            dir_q.a_in   <= wdata[CW_A_BIT];
            dir_q.chi_in <= wdata[CW_CHI_BIT];
            dir_q.b_in   <= wdata[CW_B_BIT];
            dir_q.clo_in <= wdata[CW_CLO_BIT];
        end
    end

    assign dir = dir_q;

    AST_RESET_ALL_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (dir_q == DIR_ALL_IN)); // R1

    AST_BIT_CMD_KEEPS_DIR: assert property (@(posedge clk) disable iff (!rst_n)
        bit_we |=> $stable(dir_q)); // R9

    AST_MODE_LOADS_DIR: assert property (@(posedge clk) disable iff (!rst_n)
        mode_load |=> (dir_q.a_in == $past(wdata[CW_A_BIT]))
                   && (dir_q.clo_in == $past(wdata[CW_CLO_BIT]))); // R7

endmodule

// File: rtl/ppi_port_latch.sv
// Module: one port's output latch.
// The latch supports a clear, a full load and a single-bit update.
// Clear wins over load, and load wins over the bit update. Assumes the
// caller drives at most one of them in a cycle during normal use.
module ppi_port_latch #(
    parameter int  W     = 8,
    parameter bit  HAS_BIT_CMD = 1'b0,
    localparam int IDX_W = $clog2(W)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             load,
    input  logic [W-1:0]     load_data,
    input  logic             bit_we,
    input  logic [IDX_W-1:0] bit_idx,
    input  logic             bit_val,
    output logic [W-1:0]     q
);

    logic [W-1:0] q_r;
    logic [W-1:0] q_next;

    // Work out the next latch value from the highest-priority request.
    generate
        if (HAS_BIT_CMD) begin : g_bitcmd
            always_comb begin
                q_next = q_r;
                if (clr) begin
                    q_next = '0;
                end else if (load) begin
                    q_next = load_data;
                end else if (bit_we) begin
                    q_next[bit_idx] = bit_val;
                end
            end
        end else begin : g_plain
            logic unused_bitcmd;
            assign unused_bitcmd = ^{bit_we, bit_idx, bit_val};
            always_comb begin
                q_next = q_r;
                if (clr) begin
                    q_next = '0;
                end else if (load) begin
                    q_next = load_data;
                end
            end
        end
    endgenerate

    // Register the latch; reset returns it to zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q_r <= '0;
        end else begin
            q_r <= q_next;
        end
    end

    assign q = q_r;

    AST_CLEAR_ZEROES: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (q_r == '0)); // R8

    AST_LOAD_TAKES_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        (load && !clr) |=> (q_r == $past(load_data))); // R3

    AST_ONE_BIT_MOVES: assert property (@(posedge clk) disable iff (!rst_n)
        (HAS_BIT_CMD && bit_we && !load && !clr)
            |=> ($countones(q_r ^ $past(q_r)) <= 1)
             && (q_r[$past(bit_idx)] == $past(bit_val))); // R9

    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && !load && !bit_we) |=> $stable(q_r)); // R3

endmodule

// File: rtl/ppi_read_mux.sv
// Module: read path.
// For each port it picks the pins or the latch according to direction,
// selects the register named by the address, and enables the read bus
// only during a selected read. Purely combinational; assumes the pin
// inputs are already stable in the host's clock domain.
module ppi_read_mux
    import ppi_pkg::*;
#(
    parameter int W = PORT_W,
    localparam int H = W / 2
) (
    input  logic         cs_n,
    input  logic         rd_n,
    input  logic [1:0]   addr,
    input  dir_t         dir,
    input  logic [W-1:0] pa_in,
    input  logic [W-1:0] pa_q,
    input  logic [W-1:0] pb_in,
    input  logic [W-1:0] pb_q,
    input  logic [W-1:0] pc_in,
    input  logic [W-1:0] pc_q,
    output logic [W-1:0] rdata,
    output logic         rdata_oe
);

    logic [W-1:0] a_view;
    logic [W-1:0] b_view;
    logic [W-1:0] c_view;

    // Per-port view: live pins when input, latch when output.
    always_comb begin
        a_view = dir.a_in ? pa_in : pa_q;
        b_view = dir.b_in ? pb_in : pb_q;
        c_view[W-1:H] = dir.chi_in ? pc_in[W-1:H] : pc_q[W-1:H];
        c_view[H-1:0] = dir.clo_in ? pc_in[H-1:0] : pc_q[H-1:0];
    end

    // Choose the addressed register and gate the bus enable.
    always_comb begin
        rdata_oe = ~cs_n & ~rd_n;
        unique case (reg_sel_e'(addr))
            SEL_A:    rdata = a_view;
            SEL_B:    rdata = b_view;
            SEL_C:    rdata = c_view;
            default:  rdata = '1;
        endcase
    end

endmodule

// File: rtl/ppi_parallel_io.sv
// Module: top of the programmable parallel port interface.
// It decodes host writes to the three port latches and the control
// register, drives the port enables from the direction state, and
// presents the read path. Assumes a synchronous host: strobes are
// sampled on the rising clock edge, and a write held for several cycles
// repeats the same effect.
module ppi_parallel_io
    import ppi_pkg::*;
#(
    parameter int W = PORT_W,
    localparam int H = W / 2,
    localparam int IDX_W = $clog2(W)
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         cs_n,
    input  logic         rd_n,
    input  logic         wr_n,
    input  logic [1:0]   addr,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] rdata,
    output logic         rdata_oe,
    input  logic [W-1:0] pa_in,
    output logic [W-1:0] pa_out,
    output logic         pa_oe,
    input  logic [W-1:0] pb_in,
    output logic [W-1:0] pb_out,
    output logic         pb_oe,
    input  logic [W-1:0] pc_in,
    output logic [W-1:0] pc_out,
    output logic [W-1:0] pc_oe
);

    localparam int NPORT = 3;

    logic             wr_act;
    logic [NPORT-1:0] port_load;
    logic             wr_ctrl;
    dir_t             dir;
    logic             mode_load;
    logic             bit_we;
    logic [IDX_W-1:0] bit_idx;
    logic             bit_val;
    logic [W-1:0]     latch_q [NPORT];

    // Qualify the write strobe and decode the target register.
    always_comb begin
        wr_act    = ~cs_n & ~wr_n;
        port_load = '0;
        wr_ctrl   = 1'b0;
        unique case (reg_sel_e'(addr))
            SEL_A:   port_load[0] = wr_act;
            SEL_B:   port_load[1] = wr_act;
            SEL_C:   port_load[2] = wr_act;
            default: wr_ctrl      = wr_act;
        endcase
    end

    ppi_ctrl_reg #(.W(W)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_ctrl   (wr_ctrl),
        .wdata     (wdata),
        .dir       (dir),
        .mode_load (mode_load),
        .bit_we    (bit_we),
        .bit_idx   (bit_idx),
        .bit_val   (bit_val)
    );

    // One latch per port; only Port C accepts single-bit commands.
    generate
        for (genvar p = 0; p < NPORT; p++) begin : g_port
            ppi_port_latch #(
                .W           (W),
                .HAS_BIT_CMD (p == 2)
            ) u_latch (
                .clk       (clk),
                .rst_n     (rst_n),
                .clr       (mode_load),
                .load      (port_load[p]),
                .load_data (wdata),
                .bit_we    (bit_we),
                .bit_idx   (bit_idx),
                .bit_val   (bit_val),
                .q         (latch_q[p])
            );
        end
    endgenerate

    // Drive pin-side outputs from latches and direction state.
    always_comb begin
        pa_out = latch_q[0];
        pb_out = latch_q[1];
        pc_out = latch_q[2];
        pa_oe  = ~dir.a_in;
        pb_oe  = ~dir.b_in;
        pc_oe  = {{H{~dir.chi_in}}, {H{~dir.clo_in}}};
    end

    ppi_read_mux #(.W(W)) u_rmux (
        .cs_n     (cs_n),
        .rd_n     (rd_n),
        .addr     (addr),
        .dir      (dir),
        .pa_in    (pa_in),
        .pa_q     (latch_q[0]),
        .pb_in    (pb_in),
        .pb_q     (latch_q[1]),
        .pc_in    (pc_in),
        .pc_q     (latch_q[2]),
        .rdata    (rdata),
        .rdata_oe (rdata_oe)
    );

    AST_MODE_CLEARS_OUTPUTS: assert property (@(posedge clk) disable iff (!rst_n)
        mode_load |=> (pa_out == '0) && (pb_out == '0) && (pc_out == '0)); // R8

    AST_CTRL_READS_ONES: assert property (@(posedge clk) disable iff (!rst_n)
        (rdata_oe && addr == 2'b11) |-> (rdata == '1)); // R6

    AST_INPUT_READ_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
        (rdata_oe && addr == 2'b00 && !pa_oe) |-> (rdata == pa_in)); // R5

    AST_OUTPUT_READ_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
        (rdata_oe && addr == 2'b01 && pb_oe) |-> (rdata == pb_out)); // R5

    AST_NO_SELECT_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |=> $stable(pa_out) && $stable(pb_out) && $stable(pc_out)
                 && $stable(pa_oe) && $stable(pc_oe)); // R3

endmodule

// File: tb/tb_ppi_parallel_io.sv
module tb_ppi_parallel_io;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cs_n = 1'b1;
    logic       rd_n = 1'b1;
    logic       wr_n = 1'b1;
    logic [1:0] addr = 2'b00;
    logic [7:0] wdata = 8'h00;
    logic [7:0] rdata;
    logic       rdata_oe;
    logic [7:0] pa_in = 8'h00, pb_in = 8'h00, pc_in = 8'h00;
    logic [7:0] pa_out, pb_out, pc_out, pc_oe;
    logic       pa_oe, pb_oe;

    int vectors = 0;
    int miscompares = 0;

    always #5 clk = ~clk;

    ppi_parallel_io dut (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n),
        .addr(addr), .wdata(wdata), .rdata(rdata), .rdata_oe(rdata_oe),
        .pa_in(pa_in), .pa_out(pa_out), .pa_oe(pa_oe),
        .pb_in(pb_in), .pb_out(pb_out), .pb_oe(pb_oe),
        .pc_in(pc_in), .pc_out(pc_out), .pc_oe(pc_oe)
    );

    task automatic check(input string req, input string what,
                         input logic [7:0] got, input logic [7:0] exp);
        vectors++;
        if (got !== exp) begin
            miscompares++;
            $display("FAIL %s %s: got 0x%02h expected 0x%02h", req, what, got, exp);
        end
    endtask

    // One write cycle; the effect is visible after the following rising edge.
    task automatic bus_write(input logic [1:0] a, input logic [7:0] d, input logic sel_n);
        @(negedge clk);
        addr = a; wdata = d; cs_n = sel_n; wr_n = 1'b0;
        @(negedge clk);
        cs_n = 1'b1; wr_n = 1'b1;
    endtask

    // Combinational read sampled mid-cycle.
    task automatic bus_read(input logic [1:0] a, input logic sel_n,
                            output logic [7:0] d, output logic oe);
        @(negedge clk);
        addr = a; cs_n = sel_n; rd_n = 1'b0;
        #2;
        d = rdata; oe = rdata_oe;
        cs_n = 1'b1; rd_n = 1'b1;
    endtask

    task automatic t_reset;
        logic [7:0] d; logic oe;
        check("R1", "pa_oe after reset", {7'b0, pa_oe}, 8'h00);
        check("R1", "pb_oe after reset", {7'b0, pb_oe}, 8'h00);
        check("R1", "pc_oe after reset", pc_oe, 8'h00);
        check("R1", "pc_out after reset", pc_out, 8'h00);
        pa_in = 8'h5A;
        bus_read(2'b00, 1'b0, d, oe);
        check("R5", "input read of A", d, 8'h5A);
        check("R4", "oe during read", {7'b0, oe}, 8'h01);
        #1;
        check("R4", "oe when idle", {7'b0, rdata_oe}, 8'h00);
        bus_read(2'b00, 1'b1, d, oe);
        check("R4", "oe with select high", {7'b0, oe}, 8'h00);
    endtask

    task automatic t_all_out;
        logic [7:0] d; logic oe;
        bus_write(2'b11, 8'h80, 1'b0);
        check("R7", "pa_oe all out", {7'b0, pa_oe}, 8'h01);
        check("R7", "pb_oe all out", {7'b0, pb_oe}, 8'h01);
        check("R10", "pc_oe all out", pc_oe, 8'hFF);
        bus_write(2'b00, 8'h3C, 1'b0);
        bus_write(2'b01, 8'hC3, 1'b0);
        bus_write(2'b10, 8'h96, 1'b0);
        check("R2", "A latch", pa_out, 8'h3C);
        check("R2", "B latch", pb_out, 8'hC3);
        check("R3", "C latch", pc_out, 8'h96);
        pa_in = 8'h00;
        bus_read(2'b00, 1'b0, d, oe);
        check("R5", "output read of A", d, 8'h3C);
        bus_read(2'b11, 1'b0, d, oe);
        check("R6", "control read", d, 8'hFF);
        bus_write(2'b00, 8'hFF, 1'b1);
        check("R3", "write with select high", pa_out, 8'h3C);
    endtask

    task automatic t_mode_clear;
        bus_write(2'b11, 8'h80, 1'b0);
        check("R8", "A cleared", pa_out, 8'h00);
        check("R8", "B cleared", pb_out, 8'h00);
        check("R8", "C cleared", pc_out, 8'h00);
    endtask

    task automatic t_split;
        logic [7:0] d; logic oe;
        bus_write(2'b11, 8'h8A, 1'b0);
        check("R7", "pa_oe split", {7'b0, pa_oe}, 8'h01);
        check("R7", "pb_oe split", {7'b0, pb_oe}, 8'h00);
        check("R10", "pc_oe halves", pc_oe, 8'h0F);
        bus_write(2'b10, 8'h3C, 1'b0);
        pc_in = 8'hA5;
        bus_read(2'b10, 1'b0, d, oe);
        check("R5", "mixed C read", d, 8'hAC);
        pb_in = 8'h71;
        bus_read(2'b01, 1'b0, d, oe);
        check("R5", "input read of B", d, 8'h71);
    endtask

    task automatic t_ignored_bits;
        bus_write(2'b11, 8'hE4, 1'b0);
        check("R7", "ignored bits pa_oe", {7'b0, pa_oe}, 8'h01);
        check("R7", "ignored bits pb_oe", {7'b0, pb_oe}, 8'h01);
        check("R7", "ignored bits pc_oe", pc_oe, 8'hFF);
    endtask

    task automatic t_bit_cmd;
        bus_write(2'b11, 8'h0B, 1'b0);
        check("R9", "set C5", pc_out, 8'h20);
        bus_write(2'b11, 8'h01, 1'b0);
        check("R9", "set C0", pc_out, 8'h21);
        bus_write(2'b11, 8'h0A, 1'b0);
        check("R9", "clear C5", pc_out, 8'h01);
        bus_write(2'b11, 8'h0F, 1'b0);
        check("R9", "set C7", pc_out, 8'h81);
        check("R9", "directions kept pc_oe", pc_oe, 8'hFF);
        check("R9", "directions kept pa_oe", {7'b0, pa_oe}, 8'h01);
        check("R9", "A latch untouched", pa_out, 8'h00);
    endtask

    task automatic t_reset_again;
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        check("R1", "pc_oe after second reset", pc_oe, 8'h00);
        check("R1", "pc_out after second reset", pc_out, 8'h00);
        check("R1", "pa_oe after second reset", {7'b0, pa_oe}, 8'h00);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_all_out();
        t_mode_clear();
        t_split();
        t_ignored_bits();
        t_bit_cmd();
        t_reset_again();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        #100000;
        vectors++;
        miscompares++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

endmodule